// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

The block is a down-counting watchdog that sits behind a single-cycle memory-mapped read/write port. Software programs a load value and an early-warning distance, then enables counting. The counter steps down once for every cycle on which the slow tick enable is high. That enable comes from a 32.768 kHz sleep clock, so a timeout of T milliseconds needs a load value of T·32768/1000. Software restarts the count by writing the load strobe, both for the first start and for each later kick.

When the count falls to the programmed distance, a raw interrupt flag is set. The interrupt output is that flag masked by the interrupt enable. When the count runs out, one of two things happens. If reset-request generation is enabled, an active-low reset request falls and stays low until the next system reset. If it is disabled, the counter reloads from the load value and keeps running. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Register offsets (byte addresses): 0x00 control, 0x04 load value, 0x08 load strobe, 0x0C reset-request enable, 0x10 interrupt enable, 0x14 raw status, 0x18 masked status, 0x1C interrupt clear, 0x20 update enable, 0x24 live count, 0x28 reset-request level, 0x2C early-warning distance.

Top module: `wdt_early_warn`

## Requirements
- R1: After reset the control bits, every enable bit, the load value, the distance, the count and the raw flag read 0. The reset request (0x28 bit 0 and `rst_req_n`) is 1, and `irq` is 0.
- R2: The count decreases by one on each cycle with `tick_en` high, but only while control bit 2 (count enable) and control bit 0 (watchdog clock enable) are both 1. Otherwise it holds. Control bit 1 is stored and reads back, and it has no effect on counting.
- R3: A write of data bit 0 = 1 to 0x08 while 0x20 bit 0 is 1 copies the load value (0x04) into the count at that clock edge. A tick in the same cycle is ignored.
- R4: A load-strobe write while 0x20 bit 0 is 0 leaves the count unchanged.
- R5: Raw status (0x14 bit 0) is set by a tick that takes a nonzero count to a value equal to the distance register (0x2C).
- R6: Any write to 0x1C clears the raw flag, whatever the data.
- R7: Masked status (0x18 bit 0) equals raw AND interrupt enable (0x10 bit 0), and `irq` equals the masked status.
- R8: A tick that finds the count at 1 or 0 while 0x0C bit 0 is 1 leaves the count at 0 and drives `rst_req_n` low. It stays low until `rst_n` is asserted, and 0x28 bit 0 reports its level.
- R9: The same tick with 0x0C bit 0 at 0 reloads the count from the load value, counting continues, and `rst_req_n` stays high.
- R10: Writable registers read back their value. 0x24 returns the live count. Offsets 0x08, 0x1C and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_en | input | 1 | One-cycle enable per sleep-clock period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Early-warning interrupt (masked status) |
| rst_req_n | output | 1 | Active-low reset request, sticky |

## Verification
The bench targets the expiry tick in both reset modes. A design that reloaded while reset generation was enabled would never pull the reset request low, and one that halted with it disabled would freeze the count at zero. A kick with updates disabled, and counting with only one of the two enable bits set, are both checked: a wrong gate shows up at once as a count that differs from the model. It also checks that the warning arrives exactly when the count reaches the distance, and that the masked interrupt and the output stay low while raw is set and the enable is off.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_LOAD   = 'h04;
  localparam int OFS_STRB   = 'h08;
  localparam int OFS_RSTEN  = 'h0C;
  localparam int OFS_INTEN  = 'h10;
  localparam int OFS_RAW    = 'h14;
  localparam int OFS_MASK   = 'h18;
  localparam int OFS_CLR    = 'h1C;
  localparam int OFS_UPD    = 'h20;
  localparam int OFS_COUNT  = 'h24;
  localparam int OFS_RSTLVL = 'h28;
  localparam int OFS_DIFF   = 'h2C;
  localparam int CTRL_RUN   = 2;
  localparam int CTRL_BUSCK = 1;
  localparam int CTRL_WCLK  = 0;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              raw,
  input  logic              masked,
  input  logic              rst_req_n,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  diff,
  output logic              rst_en,
  output logic              int_en,
  output logic              upd_en,
  output logic              load_pulse,
  output logic              clr_pulse
);
  logic              wr_act;
  logic [CTRL_W-1:0] ctrl_d;
  logic [CNT_W-1:0]  load_d, diff_d;
  logic              rst_en_d, int_en_d, upd_en_d;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_act     = bus_sel && bus_wr;
  assign load_pulse = wr_act && hit_addr(bus_addr, OFS_STRB) && bus_wdata[0] && upd_en;
  assign clr_pulse  = wr_act && hit_addr(bus_addr, OFS_CLR);

  always_comb begin
    ctrl_d   = ctrl;
    load_d   = load_val;
    diff_d   = diff;
    rst_en_d = rst_en;
    int_en_d = int_en;
    upd_en_d = upd_en;
    if (wr_act) begin
      if (hit_addr(bus_addr, OFS_CTRL))  ctrl_d   = bus_wdata[CTRL_W-1:0];
      if (hit_addr(bus_addr, OFS_LOAD))  load_d   = bus_wdata[CNT_W-1:0];
      if (hit_addr(bus_addr, OFS_DIFF))  diff_d   = bus_wdata[CNT_W-1:0];
      if (hit_addr(bus_addr, OFS_RSTEN)) rst_en_d = bus_wdata[0];
      if (hit_addr(bus_addr, OFS_INTEN)) int_en_d = bus_wdata[0];
      if (hit_addr(bus_addr, OFS_UPD))   upd_en_d = bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      load_val <= '0;
      diff     <= '0;
      rst_en   <= 1'b0;
      int_en   <= 1'b0;
      upd_en   <= 1'b0;
    end else begin
      ctrl     <= ctrl_d;
      load_val <= load_d;
      diff     <= diff_d;
      rst_en   <= rst_en_d;
      int_en   <= int_en_d;
      upd_en   <= upd_en_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (hit_addr(bus_addr, OFS_CTRL))   bus_rdata[CTRL_W-1:0] = ctrl;
    else if (hit_addr(bus_addr, OFS_LOAD))   bus_rdata[CNT_W-1:0]  = load_val;
    else if (hit_addr(bus_addr, OFS_DIFF))   bus_rdata[CNT_W-1:0]  = diff;
    else if (hit_addr(bus_addr, OFS_COUNT))  bus_rdata[CNT_W-1:0]  = count;
    else if (hit_addr(bus_addr, OFS_RSTEN))  bus_rdata[0]          = rst_en;
    else if (hit_addr(bus_addr, OFS_INTEN))  bus_rdata[0]          = int_en;
    else if (hit_addr(bus_addr, OFS_UPD))    bus_rdata[0]          = upd_en;
    else if (hit_addr(bus_addr, OFS_RAW))    bus_rdata[0]          = raw;
    else if (hit_addr(bus_addr, OFS_MASK))   bus_rdata[0]          = masked;
    else if (hit_addr(bus_addr, OFS_RSTLVL)) bus_rdata[0]          = rst_req_n;
  end

  // R10
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_act && hit_addr(bus_addr, OFS_LOAD)) |=> $stable(load_val));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run_en,
  input  logic             load_pulse,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] diff,
  input  logic             rst_en,
  output logic [CNT_W-1:0] count,
  output logic             warn_hit,
  output logic             rst_req_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             stepping, at_end;
  logic [CNT_W-1:0] count_d;
  logic             rstn_d;

  assign stepping = run_en && tick_en && !load_pulse;
  assign at_end   = count <= ONE;
  assign warn_hit = stepping && (count != '0) && ((count - ONE) == diff);

  always_comb begin
    count_d = count;
    rstn_d  = rst_req_n;
    if (load_pulse) begin
      count_d = load_val;
    end else if (stepping) begin
      if (!at_end) begin
        count_d = count - ONE;
      end else if (rst_en) begin
        count_d = '0;
        rstn_d  = 1'b0;
      end else begin
        count_d = load_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      rst_req_n <= 1'b1;
    end else begin
      count     <= count_d;
      rst_req_n <= rstn_d;
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_pulse) |=> $stable(count));
  // R8
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |=> !rst_req_n);
  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && at_end && !rst_en) |=> (count == $past(load_val)) && rst_req_n == $past(rst_req_n));
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_hit,
  input  logic clr_pulse,
  input  logic int_en,
  output logic raw,
  output logic masked
);
  logic raw_d;

  always_comb begin
    raw_d = raw;
    if (clr_pulse) raw_d = 1'b0;
    if (warn_hit)  raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= 1'b0;
    else        raw <= raw_d;
  end

  assign masked = raw && int_en;

  // R5
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> raw);
  // R6
  raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !warn_hit) |=> !raw);
endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req_n
);
  logic              rst_i_n;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  load_val, diff, count;
  logic              rst_en, int_en, upd_en, load_pulse, clr_pulse;
  logic              warn_hit, raw, masked, run_en;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .raw(raw), .masked(masked), .rst_req_n(rst_req_n),
    .ctrl(ctrl), .load_val(load_val), .diff(diff), .rst_en(rst_en),
    .int_en(int_en), .upd_en(upd_en), .load_pulse(load_pulse),
    .clr_pulse(clr_pulse));

  assign run_en = ctrl[CTRL_RUN] && ctrl[CTRL_WCLK];

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .tick_en(tick_en), .run_en(run_en),
    .load_pulse(load_pulse), .load_val(load_val), .diff(diff),
    .rst_en(rst_en), .count(count), .warn_hit(warn_hit),
    .rst_req_n(rst_req_n));

  wdt_irq u_irq (
    .clk(clk), .rst_n(rst_i_n), .warn_hit(warn_hit), .clr_pulse(clr_pulse),
    .int_en(int_en), .raw(raw), .masked(masked));

  assign irq = masked;

  // R4
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_STRB) && !upd_en && !tick_en)
      |=> $stable(count));
endmodule

// File: tb/tb_wdt_early_warn.sv
module tb_wdt_early_warn;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk, rst_n, tick_en, bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          irq, rst_req_n;

  int checks = 0;
  int errors = 0;
  bit tick_on = 1'b0;

  // behavioural reference state
  logic [2:0]  m_ctrl;
  logic [31:0] m_load, m_diff, m_cnt;
  logic        m_rsten, m_inten, m_upd, m_raw, m_rstn;

  wdt_early_warn dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req_n(rst_req_n));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin : model
    logic wr, strobe, step, hit;
    if (!rst_n) begin
      m_ctrl = 0; m_load = 0; m_diff = 0; m_cnt = 0;
      m_rsten = 0; m_inten = 0; m_upd = 0; m_raw = 0; m_rstn = 1;
    end else begin
      wr     = bus_sel && bus_wr;
      strobe = wr && bus_addr == 6'h08 && bus_wdata[0] && m_upd;
      step   = tick_en && m_ctrl[2] && m_ctrl[0] && !strobe;
      hit    = step && m_cnt != 0 && (m_cnt - 1) == m_diff;
      if (strobe) m_cnt = m_load;
      else if (step) begin
        if (m_cnt > 1) m_cnt = m_cnt - 1;
        else if (m_rsten) begin m_cnt = 0; m_rstn = 0; end
        else m_cnt = m_load;
      end
      if (wr && bus_addr == 6'h1C) m_raw = 0;
      if (hit) m_raw = 1;
      if (wr) case (bus_addr)
        6'h00: m_ctrl  = bus_wdata[2:0];
        6'h04: m_load  = bus_wdata;
        6'h2C: m_diff  = bus_wdata;
        6'h0C: m_rsten = bus_wdata[0];
        6'h10: m_inten = bus_wdata[0];
        6'h20: m_upd   = bus_wdata[0];
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a)
      6'h00: return {29'd0, m_ctrl};
      6'h04: return m_load;
      6'h0C: return {31'd0, m_rsten};
      6'h10: return {31'd0, m_inten};
      6'h14: return {31'd0, m_raw};
      6'h18: return {31'd0, m_raw & m_inten};
      6'h20: return {31'd0, m_upd};
      6'h24: return m_cnt;
      6'h28: return {31'd0, m_rstn};
      6'h2C: return m_diff;
      default: return 32'd0;
    endcase
  endfunction

  // tick generator: one tick every third cycle
  initial begin
    tick_en = 1'b0;
    forever begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        tick_en = tick_on && (k == 0);
      end
    end
  end

  // per-cycle comparison of the outputs against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        checks++;
        if (irq !== (m_raw & m_inten)) begin
          errors++;
          $display("FAIL R7 irq actual %0b expected %0b", irq, m_raw & m_inten);
        end
        checks++;
        if (rst_req_n !== m_rstn) begin
          errors++;
          $display("FAIL R8 rst_req_n actual %0b expected %0b", rst_req_n, m_rstn);
        end
      end
    end
  end

  task automatic bw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 exp = model_read(a);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
    end
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not finished, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    do_reset();
    // R1 / R10: reset values and unmapped offset
    for (int a = 0; a < 48; a += 4) rd(6'(a), "R1");
    rd(6'h3C, "R10");
    bw(6'h00, 32'h2); rd(6'h00, "R2 bus-clock bit readback");
    bw(6'h04, 32'd20); bw(6'h2C, 32'd5); bw(6'h20, 32'd1);
    rd(6'h04, "R10"); rd(6'h2C, "R10");
    bw(6'h08, 32'd1); rd(6'h24, "R3 initial load");
    bw(6'h10, 32'd1);
    tick_on = 1'b1;
    idle(10); rd(6'h24, "R2 bit1 only, no counting");
    bw(6'h00, 32'h5);
    idle(60);
    rd(6'h24, "R2 counting"); rd(6'h14, "R5"); rd(6'h18, "R7");
    bw(6'h1C, 32'hDEAD_0000); rd(6'h14, "R6 clear with arbitrary data");
    rd(6'h08, "R10 strobe reads 0"); rd(6'h1C, "R10 clear reads 0");
    bw(6'h08, 32'd1); rd(6'h24, "R3 kick");
    bw(6'h20, 32'd0); idle(7);
    bw(6'h08, 32'd1); rd(6'h24, "R4 strobe ignored");
    bw(6'h00, 32'h4); idle(20); rd(6'h24, "R2 no watchdog clock enable");
    bw(6'h00, 32'h1); idle(20); rd(6'h24, "R2 no count enable");
    bw(6'h00, 32'h5); bw(6'h20, 32'd1);
    for (int i = 0; i < 12; i++) begin
      idle(13); rd(6'h24, "R9 reload and run"); rd(6'h28, "R9");
    end
    bw(6'h10, 32'd0); idle(70);
    rd(6'h14, "R5"); rd(6'h18, "R7 masked off");
    bw(6'h10, 32'd1); rd(6'h18, "R7");
    bw(6'h2C, 32'd0); bw(6'h1C, 32'd0); bw(6'h0C, 32'd1); bw(6'h08, 32'd1);
    idle(80);
    rd(6'h28, "R8 reset request low"); rd(6'h24, "R8 count at zero"); rd(6'h14, "R5 distance 0");
    bw(6'h08, 32'd1); idle(30); rd(6'h28, "R8 sticky after kick");
    tick_on = 1'b0;
    do_reset();
    rd(6'h28, "R1 released by reset"); rd(6'h24, "R1"); rd(6'h00, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule